// File: doc/BRIEF.md
# Sawtooth LFO Bank with Encoded Rates

This block holds a bank of low-frequency oscillators that share a single phase adder. Each oscillator keeps a 22-bit phase counter and an 8-bit rate code. A host writes a rate code into any oscillator. A one-cycle sample strobe then starts a sweep. During the sweep the adder visits the oscillators one per clock, in index order from 0 upward, and adds each oscillator's decoded increment to its phase. A single-cycle pulse marks the end of the sweep.

The rate code is split into a 3-bit scale in bits 7..5 and a 5-bit value in bits 4..0. These turn into an increment through a base table and a shift table, so small codes give fine steps and large codes give coarse ones. A read port returns a folded 21-bit phase for the oscillator it addresses. When the top phase bit is set, the lower 21 bits are inverted before they are returned. The result is a rising-then-falling ramp that a consumer treats as a fraction from 0 to 1.

Top module: `lfo_bank`

## Requirements
- R1: While reset is asserted and after it is released, every phase counter and every rate code is zero, `sweep_done` and `rd_valid` are low, and `rd_data` reads zero. A strobe issued before any rate write leaves every phase at zero.
- R2: The increment for code c is base[s] + (v << shift[s]), where s = c[7:5] and v = c[4:0]. The base table is {0, 32, 64, 128, 256, 512, 1024, 2048} and the shift table is {0, 0, 1, 2, 3, 4, 5, 6}, both indexed by s.
- R3: Each accepted strobe advances every oscillator exactly once by its own increment. The oscillators are visited in index order from 0 to N-1, one per clock.
- R4: A phase counter wraps modulo 2^22 and never saturates.
- R5: Read data is phase[20:0] when phase[21] is 0, and the bitwise inverse of phase[20:0] when phase[21] is 1.
- R6: `rd_data` and `rd_valid` appear one clock after `rd_en` is sampled. `rd_valid` is high for exactly the cycles that follow a cycle in which `rd_en` was sampled.
- R7: `sweep_done` is high for exactly one cycle. It rises at the 25th rising edge, counting the edge that samples the strobe, which is the edge that updates the last oscillator.
- R8: Writing a rate code leaves that oscillator's phase unchanged. The new code takes effect from the next sweep.
- R9: A strobe that arrives while a sweep is in progress is ignored, so that oscillator advances only once.
- R10: A write with an index of N or above changes no oscillator. A read with an index of N or above returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle sample strobe that starts a sweep |
| wr_en | input | 1 | Rate-code write enable |
| wr_idx | input | 5 | Oscillator index for the write |
| wr_code | input | 8 | Rate code: scale in bits 7..5, value in bits 4..0 |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Oscillator index for the read |
| rd_data | output | 21 | Folded phase of the addressed oscillator |
| rd_valid | output | 1 | `rd_data` is valid for the request made in the previous cycle |
| sweep_done | output | 1 | One-cycle pulse after the last oscillator has been updated |

## Verification
A wrong decoded increment or a wrong adder result shows up in the phase of the affected oscillator at the first read after one sweep. Because the phases accumulate, the error also grows with every further sweep. A sequencer that skips an oscillator, visits one twice, or restarts on a second strobe moves `sweep_done` away from its fixed 25-edge position, and it also leaves phases off from the expected multiple of the increment. A folding fault stays hidden until the phase crosses the half-range point, so the bench drives an oscillator past that point and then past the wrap.

// File: rtl/lfo_pkg.sv
package lfo_pkg;
  localparam int SCALE_W = 3;
  localparam int VAL_W   = 5;
  localparam int CODE_W  = SCALE_W + VAL_W;
  localparam int INC_W   = 12;

  // base step for a scale: zero for scale 0, otherwise 16 doubled scale times
  function automatic logic [INC_W-1:0] rate_base(input logic [SCALE_W-1:0] s);
    if (s == '0) return '0;
    return INC_W'(16) << s;
  endfunction

  // left shift applied to the value field for a scale
  function automatic logic [SCALE_W-1:0] rate_shift(input logic [SCALE_W-1:0] s);
    if (s == '0) return '0;
    return s - SCALE_W'(1);
  endfunction
endpackage

// File: rtl/lfo_rate_decode.sv
module lfo_rate_decode
  import lfo_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [INC_W-1:0]  inc_o
);
  logic [SCALE_W-1:0] scale;
  logic [VAL_W-1:0]   val;

  always_comb begin
    scale = code_i[CODE_W-1:VAL_W];
    val   = code_i[VAL_W-1:0];
    inc_o = rate_base(scale) + (INC_W'(val) << rate_shift(scale));
  end
endmodule

// File: rtl/lfo_sweep_seq.sv
module lfo_sweep_seq #(
  parameter int NUM_OSC = 24,
  localparam int IDX_W  = $clog2(NUM_OSC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic             upd_en_o,
  output logic [IDX_W-1:0] upd_idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_OSC - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (busy_q) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end else if (tick_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign upd_en_o  = busy_q;
  assign upd_idx_o = idx_q;
  assign done_o    = done_q;

  // R3: the visiting index never leaves the bank
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(idx_q) < NUM_OSC));

  // R7: the end-of-sweep pulse lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: a strobe during a sweep does not restart the index
  p_tick_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick_i && idx_q != LAST) |=> (busy_q && idx_q == $past(idx_q) + IDX_W'(1)));
endmodule

// File: rtl/lfo_fold.sv
module lfo_fold #(
  parameter int PHASE_W = 22,
  localparam int OUT_W  = PHASE_W - 1
) (
  input  logic [PHASE_W-1:0] phase_i,
  output logic [OUT_W-1:0]   fold_o
);
  always_comb begin
    if (phase_i[PHASE_W-1]) fold_o = ~phase_i[OUT_W-1:0];
    else                    fold_o = phase_i[OUT_W-1:0];
  end
endmodule

// File: rtl/lfo_bank.sv
module lfo_bank
  import lfo_pkg::*;
#(
  parameter int NUM_OSC = 24,
  parameter int PHASE_W = 22,
  localparam int IDX_W  = $clog2(NUM_OSC),
  localparam int OUT_W  = PHASE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [OUT_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              sweep_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_OSC - 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // sweep sequencer
  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;

  lfo_sweep_seq #(.NUM_OSC(NUM_OSC)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (tick),
    .upd_en_o  (upd_en),
    .upd_idx_o (upd_idx),
    .done_o    (sweep_done)
  );

  // per-oscillator state
  logic [CODE_W-1:0]  code_q  [NUM_OSC];
  logic [PHASE_W-1:0] phase_q [NUM_OSC];

  // shared datapath: select, decode, add
  logic [CODE_W-1:0]  sel_code;
  logic [PHASE_W-1:0] sel_phase;
  logic [INC_W-1:0]   sel_inc;
  logic [PHASE_W-1:0] sum;

  always_comb begin
    sel_code  = '0;
    sel_phase = '0;
    for (int i = 0; i < NUM_OSC; i++) begin
      if (upd_idx == IDX_W'(i)) begin
        sel_code  = code_q[i];
        sel_phase = phase_q[i];
      end
    end
  end

  lfo_rate_decode i_dec (
    .code_i (sel_code),
    .inc_o  (sel_inc)
  );

  assign sum = sel_phase + PHASE_W'(sel_inc);

  generate
    for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
      logic code_en, phase_en;
      logic [CODE_W-1:0]  code_d;
      logic [PHASE_W-1:0] phase_d;

      always_comb begin
        code_en  = wr_en && (wr_idx == IDX_W'(g));
        phase_en = upd_en && (upd_idx == IDX_W'(g));
        code_d   = code_en  ? wr_code : code_q[g];
        phase_d  = phase_en ? sum     : phase_q[g];
      end

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
          code_q[g]  <= '0;
          phase_q[g] <= '0;
        end else begin
          code_q[g]  <= code_d;
          phase_q[g] <= phase_d;
        end
      end

      // R8: a phase moves only in its own sweep slot, never on a rate write
      p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
        !(upd_en && upd_idx == IDX_W'(g)) |=> $stable(phase_q[g]));
    end
  endgenerate

  // read port
  logic [PHASE_W-1:0] rd_phase;
  logic [OUT_W-1:0]   rd_fold;
  logic [OUT_W-1:0]   rd_data_d;
  logic               rd_data_q;
  logic [OUT_W-1:0]   rd_q;

  always_comb begin
    rd_phase = '0;
    for (int i = 0; i < NUM_OSC; i++) begin
      if (rd_idx == IDX_W'(i)) rd_phase = phase_q[i];
    end
  end

  lfo_fold #(.PHASE_W(PHASE_W)) i_fold (
    .phase_i (rd_phase),
    .fold_o  (rd_fold)
  );

  assign rd_data_d = rd_en ? rd_fold : rd_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q      <= '0;
      rd_data_q <= 1'b0;
    end else begin
      rd_q      <= rd_data_d;
      rd_data_q <= rd_en;
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = rd_data_q;

  // R6: a sampled request is answered on the next cycle
  p_rd_latency_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_en |=> rd_valid);

  // R10: reads beyond the bank return zero
  p_rd_oob_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && int'(rd_idx) >= NUM_OSC) |=> (rd_data == '0));

  // R7: the pulse follows the update of the last oscillator
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd_en && upd_idx == LAST) |=> sweep_done);
endmodule

// File: tb/test_lfo_bank.sv
module test_lfo_bank;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, wr_en, rd_en;
  logic [4:0]  wr_idx, rd_idx;
  logic [7:0]  wr_code;
  logic [20:0] rd_data;
  logic        rd_valid, sweep_done;

  always #4 clk = ~clk;

  lfo_bank i_lfo_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_code(wr_code), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_valid(rd_valid), .sweep_done(sweep_done)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0]  code_m  [N];
  logic [21:0] phase_m [N];

  // {index, code, number of strobes}
  localparam logic [20:0] VEC [0:7] = '{
    {5'd0,  8'h01, 8'd3},  {5'd4,  8'h1F, 8'd5},
    {5'd9,  8'h25, 8'd7},  {5'd13, 8'h4A, 8'd4},
    {5'd17, 8'h73, 8'd6},  {5'd20, 8'h9C, 8'd9},
    {5'd22, 8'hC8, 8'd11}, {5'd23, 8'hE7, 8'd8}
  };

  function automatic logic [11:0] exp_inc(input logic [7:0] c);
    logic [11:0] b;
    int sh;
    case (c[7:5])
      3'd0: begin b = 12'd0;    sh = 0; end
      3'd1: begin b = 12'd32;   sh = 0; end
      3'd2: begin b = 12'd64;   sh = 1; end
      3'd3: begin b = 12'd128;  sh = 2; end
      3'd4: begin b = 12'd256;  sh = 3; end
      3'd5: begin b = 12'd512;  sh = 4; end
      3'd6: begin b = 12'd1024; sh = 5; end
      default: begin b = 12'd2048; sh = 6; end
    endcase
    return b + ({7'd0, c[4:0]} << sh);
  endfunction

  function automatic logic [20:0] exp_fold(input logic [21:0] p);
    return p[21] ? ~p[20:0] : p[20:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin code_m[i] = 8'd0; phase_m[i] = 22'd0; end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [7:0] code);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_code = code;
    @(negedge clk); wr_en = 1'b0;
    if (idx < N) code_m[idx] = code;
  endtask

  task automatic rd(input logic [4:0] idx, output logic [20:0] data, output logic valid);
    @(negedge clk); rd_en = 1'b1; rd_idx = idx;
    @(negedge clk); rd_en = 1'b0; data = rd_data; valid = rd_valid;
  endtask

  // one strobe; returns the negedge count at which the done pulse was seen
  task automatic strobe(input int hold, output int seen);
    int cnt = 0;
    seen = -1;
    @(negedge clk); tick = 1'b1;
    while (cnt < 40) begin
      @(negedge clk); cnt++;
      if (cnt >= hold) tick = 1'b0;
      if (sweep_done) begin seen = cnt; break; end
    end
    tick = 1'b0;
    for (int i = 0; i < N; i++) phase_m[i] = phase_m[i] + 22'(exp_inc(code_m[i]));
  endtask

  task automatic run(input int n);
    int s;
    for (int k = 0; k < n; k++) strobe(1, s);
  endtask

  task automatic cmp_osc(input logic [4:0] idx, input string req);
    logic [20:0] d; logic v;
    rd(idx, d, v);
    check(d == exp_fold(phase_m[idx]), req, d, exp_fold(phase_m[idx]));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [20:0] d; logic v; int s;
    tick = 0; wr_en = 0; rd_en = 0; wr_idx = 0; rd_idx = 0; wr_code = 0;
    rst_n = 1'b0;
    @(negedge clk);
    check(sweep_done == 0 && rd_valid == 0 && rd_data == 0, "R1 in reset", rd_data, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();

    // R1: reset state and zero codes
    rd(5'd0, d, v);  check(d == 0, "R1 osc0 zero", d, 0);
    rd(5'd23, d, v); check(d == 0, "R1 osc23 zero", d, 0);
    strobe(1, s);
    rd(5'd11, d, v); check(d == 0, "R1 no advance with reset codes", d, 0);

    // R7: done timing and width
    check(s == 25, "R7 done position", s, 25);
    @(negedge clk); check(sweep_done == 0, "R7 single cycle", sweep_done, 0);

    // R6: read latency
    @(negedge clk); rd_en = 1'b1; rd_idx = 5'd2;
    @(negedge clk); rd_en = 1'b0;
    check(rd_valid == 1, "R6 valid after one cycle", rd_valid, 1);
    @(negedge clk);
    check(rd_valid == 0, "R6 valid drops", rd_valid, 0);

    // R2: every scale, small and large value, one strobe each
    for (int sc = 0; sc < 8; sc++) begin
      wr(5'd3, {sc[2:0], 5'd31}); strobe(1, s); cmp_osc(5'd3, "R2 scale v31");
      wr(5'd3, {sc[2:0], 5'd1});  strobe(1, s); cmp_osc(5'd3, "R2 scale v1");
    end

    // R3: vector table, all oscillators advance on each strobe
    for (int k = 0; k < 8; k++) begin
      wr(VEC[k][20:16], VEC[k][15:8]);
      run(int'(VEC[k][7:0]));
      cmp_osc(VEC[k][20:16], "R3 vector");
    end
    for (int i = 0; i < N; i++) cmp_osc(5'(i), "R3 all oscillators");

    // R8: rate write leaves phase, new rate from next sweep
    rd(5'd9, d, v);
    wr(5'd9, 8'hB3);
    begin logic [20:0] d2; rd(5'd9, d2, v); check(d2 == d, "R8 phase held on write", d2, d); end
    strobe(1, s); cmp_osc(5'd9, "R8 new rate applied");

    // R9: strobe held across the sweep is seen once
    wr(5'd6, 8'h40);
    strobe(5, s);
    cmp_osc(5'd6, "R9 single advance");
    check(s == 25, "R9 done position", s, 25);

    // R10: out-of-range write and read
    wr(5'd24, 8'hFF); wr(5'd31, 8'hFF);
    strobe(1, s);
    cmp_osc(5'd0, "R10 osc0 unaffected");
    cmp_osc(5'd23, "R10 osc23 unaffected");
    rd(5'd25, d, v); check(d == 0, "R10 read oob zero", d, 0);

    // R5 and R4: fold past half range, then wrap
    do_reset();
    wr(5'd10, 8'hFF);
    run(600);
    check(phase_m[10][21] == 1'b1, "R5 model crossed half", phase_m[10][21], 1);
    rd(5'd10, d, v);
    check(d == ~phase_m[10][20:0], "R5 folded read", d, ~phase_m[10][20:0]);
    run(441);
    check(phase_m[10] < 22'd4032, "R4 model wrapped", phase_m[10], 0);
    cmp_osc(5'd10, "R4 wrap");

    // R1: reset mid-run clears phases
    do_reset();
    rd(5'd10, d, v); check(d == 0, "R1 reset clears phase", d, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule